// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block takes the moment a core decides to trap and turns it into a complete, consistent entry state. In one cycle it sees the raise requests: a generic trap with its cause code, an unaligned-access report, a fetch-side bus error, a data-side bus error and a debug request. It also sees the faulting PC, a faulting address and the live status word. It picks the handler vector and loads the save and cause registers. It also produces the status word the core must adopt.

General traps go to the kernel or user vector, or to the double vector when a trap is already being handled. Debug traps are gated by the current interrupt level. When accepted, they save the whole status word and raise the level to the configured debug level. On the clock edge after the request, the core receives a one-cycle valid strobe with a two-bit vector select. On that same edge the register outputs hold the new state.

Status word layout, decoded by the core: bits [3:0] interrupt level, bit 4 exception-mode, bit 5 user-mode, bits [7:6] carried through. Vector select codes: 0 kernel, 1 user, 2 double, 3 debug.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every register output is zero and the valid strobe is low.
- R2: A general trap taken with exception-mode (bit 4) clear stores the PC in the level-1 PC register. It selects vector 1 when user-mode (bit 5) is set and vector 0 when it is clear.
- R3: A general trap taken with exception-mode set selects vector 2. When HAS_DEPC is 1 it stores the PC in the double-trap PC register and leaves the level-1 PC untouched; when HAS_DEPC is 0 it stores the PC in the level-1 PC register.
- R4: Every general trap writes its cause into the cause register. The output status word is the input status word with bit 4 set.
- R5: The fault-address register is written only by address-carrying traps: a generic trap flagged as carrying an address, an unaligned trap, or a bus error. Any other trap leaves it unchanged.
- R6: A debug request is accepted only when the current interrupt level is strictly below DEBUG_LEVEL. A rejected debug request changes nothing.
- R7: An accepted debug trap writes the debug cause and stores the PC and the whole input status word in the debug-level save registers. It selects vector 3. The output status word has bits [3:0] set to DEBUG_LEVEL, bit 4 set, and the other bits kept.
- R8: An unaligned report traps with cause ALIGN_CAUSE only when UA_TRAP_EN is 1 and HW_ALIGN is 0. Otherwise it is ignored.
- R9: A fetch-side bus error traps with cause IBUS_CAUSE and records the address input as the fault address.
- R10: A data-side bus error traps with cause DBUS_CAUSE and records the address input as the fault address.
- R11: An accepted debug request wins over any simultaneous general source, which is dropped. Among the general sources, the order is fetch bus error, then data bus error, then unaligned, then generic.
- R12: The valid strobe is high for exactly the one cycle after an accepted request, and the save registers change on that same edge. Without a request, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_req_i | input | 1 | Generic trap request pulse |
| gen_cause_i | input | CAUSE_W | Cause code of the generic trap |
| gen_has_addr_i | input | 1 | Generic trap carries a fault address |
| ua_req_i | input | 1 | Unaligned-access report pulse |
| ibus_err_i | input | 1 | Fetch-side bus error pulse |
| dbus_err_i | input | 1 | Data-side bus error pulse |
| dbg_req_i | input | 1 | Debug trap request pulse |
| dbg_cause_i | input | DBGC_W | Debug cause code |
| pc_i | input | PC_W | PC of the trapping instruction |
| addr_i | input | PC_W | Fault address (fetch or data) |
| ps_i | input | 8 | Current status word |
| cur_level_i | input | 4 | Current interrupt level |
| vec_valid_o | output | 1 | One-cycle entry strobe |
| vec_sel_o | output | 2 | Vector select |
| epc1_o | output | PC_W | Level-1 trap PC |
| depc_o | output | PC_W | Double-trap PC |
| dbg_epc_o | output | PC_W | Debug-level trap PC |
| dbg_eps_o | output | 8 | Debug-level saved status word |
| exc_cause_o | output | CAUSE_W | General trap cause |
| exc_vaddr_o | output | PC_W | Fault address |
| dbg_cause_o | output | DBGC_W | Debug cause |
| ps_o | output | 8 | Status word to adopt on entry |

## Verification
The bench sweeps all 256 status words through a general trap, so the kernel/user/double choice and the PC destination are checked for every bit combination. A design that tested the user-mode bit before exception-mode, or that wrote both PC registers, would fail here. It sweeps every interrupt level against the debug gate, with and without a simultaneous general trap. An off-by-one compare would accept or reject the request at level 6, and a bad arbitration would overwrite the general cause or drop the general trap when debug is rejected. A second instance without the double-trap PC and with hardware alignment checks the PC redirect and the silently ignored unaligned report. Stacked source combinations check the general priority order and that only address-carrying traps move the fault address.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_W       = 8;
  localparam int INTLVL_LSB = 0;
  localparam int INTLVL_W   = 4;
  localparam int EXCM_BIT   = 4;
  localparam int UM_BIT     = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;
endpackage

// File: rtl/exc_gen_arb.sv
module exc_gen_arb #(
  parameter int CAUSE_W     = 6,
  parameter int ALIGN_CAUSE = 9,
  parameter int IBUS_CAUSE  = 12,
  parameter int DBUS_CAUSE  = 13,
  parameter bit UA_TRAP_EN  = 1'b1,
  parameter bit HW_ALIGN    = 1'b0
) (
  input  logic               gen_req_i,
  input  logic [CAUSE_W-1:0] gen_cause_i,
  input  logic               gen_has_addr_i,
  input  logic               ua_req_i,
  input  logic               ibus_err_i,
  input  logic               dbus_err_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               addr_wr_o
);
  localparam bit UA_TRAPS = UA_TRAP_EN && !HW_ALIGN;
  localparam logic [CAUSE_W-1:0] C_ALIGN = CAUSE_W'(ALIGN_CAUSE);
  localparam logic [CAUSE_W-1:0] C_IBUS  = CAUSE_W'(IBUS_CAUSE);
  localparam logic [CAUSE_W-1:0] C_DBUS  = CAUSE_W'(DBUS_CAUSE);

  logic ua_live;
  assign ua_live = ua_req_i & UA_TRAPS;

  always_comb begin
    take_o    = 1'b1;
    cause_o   = gen_cause_i;
    addr_wr_o = 1'b1;
    if (ibus_err_i) begin
      cause_o = C_IBUS;
    end else if (dbus_err_i) begin
      cause_o = C_DBUS;
    end else if (ua_live) begin
      cause_o = C_ALIGN;
    end else if (gen_req_i) begin
      addr_wr_o = gen_has_addr_i;
    end else begin
      take_o    = 1'b0;
      addr_wr_o = 1'b0;
    end
  end
endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate
  import exc_entry_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6
) (
  input  logic                dbg_req_i,
  input  logic [INTLVL_W-1:0] cur_level_i,
  output logic                take_o
);
  localparam logic [INTLVL_W-1:0] DL = INTLVL_W'(DEBUG_LEVEL);
  assign take_o = dbg_req_i && (cur_level_i < DL);
endmodule

// File: rtl/exc_entry_next.sv
module exc_entry_next
  import exc_entry_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic            gen_take_i,
  input  logic            dbg_take_i,
  input  logic            addr_wr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            we_epc1_o,
  output logic            we_depc_o,
  output logic            we_cause_o,
  output logic            we_vaddr_o,
  output logic            we_dbg_o,
  output logic            valid_nxt_o,
  output vec_e            vec_nxt_o,
  output logic [PS_W-1:0] ps_nxt_o
);
  localparam logic [INTLVL_W-1:0] DL = INTLVL_W'(DEBUG_LEVEL);

  logic gen_win;
  logic in_exc;
  assign gen_win = gen_take_i & ~dbg_take_i;
  assign in_exc  = ps_i[EXCM_BIT];

  always_comb begin
    we_epc1_o   = 1'b0;
    we_depc_o   = 1'b0;
    we_cause_o  = 1'b0;
    we_vaddr_o  = 1'b0;
    we_dbg_o    = 1'b0;
    valid_nxt_o = dbg_take_i | gen_take_i;
    vec_nxt_o   = VEC_KERNEL;
    ps_nxt_o    = ps_i;
    ps_nxt_o[EXCM_BIT] = 1'b1;
    if (dbg_take_i) begin
      we_dbg_o  = 1'b1;
      vec_nxt_o = VEC_DEBUG;
      ps_nxt_o[INTLVL_LSB +: INTLVL_W] = DL;
    end else if (gen_win) begin
      we_cause_o = 1'b1;
      we_vaddr_o = addr_wr_i;
      if (in_exc) begin
        vec_nxt_o = VEC_DOUBLE;
        we_depc_o = HAS_DEPC;
        we_epc1_o = !HAS_DEPC;
      end else begin
        we_epc1_o = 1'b1;
        vec_nxt_o = ps_i[UM_BIT] ? VEC_USER : VEC_KERNEL;
      end
    end
  end
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
  import exc_entry_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DBGC_W   = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_epc1_i,
  input  logic               we_depc_i,
  input  logic               we_cause_i,
  input  logic               we_vaddr_i,
  input  logic               we_dbg_i,
  input  logic               valid_nxt_i,
  input  vec_e               vec_nxt_i,
  input  logic [PS_W-1:0]    ps_nxt_i,
  input  logic [PS_W-1:0]    ps_cur_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    addr_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [DBGC_W-1:0]  dbg_cause_i,
  output logic               vec_valid_o,
  output logic [1:0]         vec_sel_o,
  output logic [PC_W-1:0]    epc1_o,
  output logic [PC_W-1:0]    depc_o,
  output logic [PC_W-1:0]    dbg_epc_o,
  output logic [PS_W-1:0]    dbg_eps_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [PC_W-1:0]    exc_vaddr_o,
  output logic [DBGC_W-1:0]  dbg_cause_o,
  output logic [PS_W-1:0]    ps_o
);
  logic ps_en;
  assign ps_en = we_dbg_i | we_cause_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_sel_o   <= 2'd0;
    end else begin
      vec_valid_o <= valid_nxt_i;
      if (valid_nxt_i) vec_sel_o <= vec_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc1_o      <= '0;
      exc_cause_o <= '0;
      exc_vaddr_o <= '0;
      ps_o        <= '0;
    end else begin
      if (we_epc1_i)  epc1_o      <= pc_i;
      if (we_cause_i) exc_cause_o <= cause_i;
      if (we_vaddr_i) exc_vaddr_o <= addr_i;
      if (ps_en)      ps_o        <= ps_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_epc_o   <= '0;
      dbg_eps_o   <= '0;
      dbg_cause_o <= '0;
    end else if (we_dbg_i) begin
      dbg_epc_o   <= pc_i;
      dbg_eps_o   <= ps_cur_i;
      dbg_cause_o <= dbg_cause_i;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         depc_o <= '0;
        else if (we_depc_i) depc_o <= pc_i;
      end
    end else begin : g_no_depc
      logic unused_we;
      assign unused_we = we_depc_i;
      assign depc_o = '0;
    end
  endgenerate
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DBGC_W      = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter bit UA_TRAP_EN  = 1'b1,
  parameter bit HW_ALIGN    = 1'b0,
  parameter int ALIGN_CAUSE = 9,
  parameter int IBUS_CAUSE  = 12,
  parameter int DBUS_CAUSE  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_req_i,
  input  logic [CAUSE_W-1:0]  gen_cause_i,
  input  logic                gen_has_addr_i,
  input  logic                ua_req_i,
  input  logic                ibus_err_i,
  input  logic                dbus_err_i,
  input  logic                dbg_req_i,
  input  logic [DBGC_W-1:0]   dbg_cause_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [PC_W-1:0]     addr_i,
  input  logic [PS_W-1:0]     ps_i,
  input  logic [INTLVL_W-1:0] cur_level_i,
  output logic                vec_valid_o,
  output logic [1:0]          vec_sel_o,
  output logic [PC_W-1:0]     epc1_o,
  output logic [PC_W-1:0]     depc_o,
  output logic [PC_W-1:0]     dbg_epc_o,
  output logic [PS_W-1:0]     dbg_eps_o,
  output logic [CAUSE_W-1:0]  exc_cause_o,
  output logic [PC_W-1:0]     exc_vaddr_o,
  output logic [DBGC_W-1:0]   dbg_cause_o,
  output logic [PS_W-1:0]     ps_o
);
  logic               gen_take, dbg_take, addr_wr;
  logic [CAUSE_W-1:0] gen_cause;
  logic               we_epc1, we_depc, we_cause, we_vaddr, we_dbg, valid_nxt;
  vec_e               vec_nxt;
  logic [PS_W-1:0]    ps_nxt;

  exc_gen_arb #(
    .CAUSE_W(CAUSE_W), .ALIGN_CAUSE(ALIGN_CAUSE), .IBUS_CAUSE(IBUS_CAUSE),
    .DBUS_CAUSE(DBUS_CAUSE), .UA_TRAP_EN(UA_TRAP_EN), .HW_ALIGN(HW_ALIGN)
  ) u_arb (
    .gen_req_i(gen_req_i), .gen_cause_i(gen_cause_i),
    .gen_has_addr_i(gen_has_addr_i), .ua_req_i(ua_req_i),
    .ibus_err_i(ibus_err_i), .dbus_err_i(dbus_err_i),
    .take_o(gen_take), .cause_o(gen_cause), .addr_wr_o(addr_wr)
  );

  exc_dbg_gate #(.DEBUG_LEVEL(DEBUG_LEVEL)) u_gate (
    .dbg_req_i(dbg_req_i), .cur_level_i(cur_level_i), .take_o(dbg_take)
  );

  exc_entry_next #(.DEBUG_LEVEL(DEBUG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_next (
    .gen_take_i(gen_take), .dbg_take_i(dbg_take), .addr_wr_i(addr_wr),
    .ps_i(ps_i), .we_epc1_o(we_epc1), .we_depc_o(we_depc),
    .we_cause_o(we_cause), .we_vaddr_o(we_vaddr), .we_dbg_o(we_dbg),
    .valid_nxt_o(valid_nxt), .vec_nxt_o(vec_nxt), .ps_nxt_o(ps_nxt)
  );

  exc_save_regs #(
    .PC_W(PC_W), .CAUSE_W(CAUSE_W), .DBGC_W(DBGC_W), .HAS_DEPC(HAS_DEPC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_epc1_i(we_epc1), .we_depc_i(we_depc), .we_cause_i(we_cause),
    .we_vaddr_i(we_vaddr), .we_dbg_i(we_dbg), .valid_nxt_i(valid_nxt),
    .vec_nxt_i(vec_nxt), .ps_nxt_i(ps_nxt), .ps_cur_i(ps_i),
    .pc_i(pc_i), .addr_i(addr_i), .cause_i(gen_cause),
    .dbg_cause_i(dbg_cause_i),
    .vec_valid_o(vec_valid_o), .vec_sel_o(vec_sel_o), .epc1_o(epc1_o),
    .depc_o(depc_o), .dbg_epc_o(dbg_epc_o), .dbg_eps_o(dbg_eps_o),
    .exc_cause_o(exc_cause_o), .exc_vaddr_o(exc_vaddr_o),
    .dbg_cause_o(dbg_cause_o), .ps_o(ps_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W     = 6,
  parameter int DEBUG_LEVEL = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gen_req_i,
  input logic                ua_req_i,
  input logic                ibus_err_i,
  input logic                dbus_err_i,
  input logic                dbg_req_i,
  input logic [PS_W-1:0]     ps_i,
  input logic [INTLVL_W-1:0] cur_level_i,
  input logic                vec_valid_o,
  input logic [1:0]          vec_sel_o,
  input logic [PS_W-1:0]     ps_o,
  input logic [CAUSE_W-1:0]  exc_cause_o
);
  localparam logic [INTLVL_W-1:0] DL = INTLVL_W'(DEBUG_LEVEL);

  logic req_any, gen_any;
  assign gen_any = gen_req_i | ibus_err_i | dbus_err_i | ua_req_i;
  assign req_any = gen_any | dbg_req_i;

  p_strobe_origin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(req_any));

  p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> $stable(exc_cause_o));

  p_excm_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ps_o[EXCM_BIT]);

  p_debug_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && cur_level_i < DL) |=> (vec_valid_o && vec_sel_o == VEC_DEBUG));

  p_debug_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && cur_level_i >= DL && !gen_any) |=> !vec_valid_o);

  p_double_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_req_i || ibus_err_i || dbus_err_i) && ps_i[EXCM_BIT] && !dbg_req_i)
      |=> (vec_valid_o && vec_sel_o == VEC_DOUBLE));

  p_mode_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req_i && !ps_i[EXCM_BIT] && !dbg_req_i)
      |=> (vec_sel_o == ($past(ps_i[UM_BIT]) ? VEC_USER : VEC_KERNEL)));

  p_debug_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_sel_o == VEC_DEBUG)
      |-> ps_o[INTLVL_LSB +: INTLVL_W] == DL);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.CAUSE_W(CAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req_i), .ua_req_i(ua_req_i),
  .ibus_err_i(ibus_err_i), .dbus_err_i(dbus_err_i), .dbg_req_i(dbg_req_i),
  .ps_i(ps_i), .cur_level_i(cur_level_i), .vec_valid_o(vec_valid_o),
  .vec_sel_o(vec_sel_o), .ps_o(ps_o), .exc_cause_o(exc_cause_o)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        gen_req_i = 0, gen_has_addr_i = 0, ua_req_i = 0;
  logic        ibus_err_i = 0, dbus_err_i = 0, dbg_req_i = 0;
  logic [5:0]  gen_cause_i = 0, dbg_cause_i = 0;
  logic [31:0] pc_i = 0, addr_i = 0;
  logic [7:0]  ps_i = 0;
  logic [3:0]  cur_level_i = 0;

  logic        a_valid, b_valid;
  logic [1:0]  a_vec, b_vec;
  logic [31:0] a_epc1, a_depc, a_depc_unused, a_dbg_epc, a_vaddr;
  logic [31:0] b_epc1, b_depc, b_dbg_epc, b_vaddr;
  logic [7:0]  a_eps, a_ps, b_eps, b_ps;
  logic [5:0]  a_cause, a_dbgc, b_cause, b_dbgc;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req_i), .gen_cause_i(gen_cause_i),
    .gen_has_addr_i(gen_has_addr_i), .ua_req_i(ua_req_i), .ibus_err_i(ibus_err_i),
    .dbus_err_i(dbus_err_i), .dbg_req_i(dbg_req_i), .dbg_cause_i(dbg_cause_i),
    .pc_i(pc_i), .addr_i(addr_i), .ps_i(ps_i), .cur_level_i(cur_level_i),
    .vec_valid_o(a_valid), .vec_sel_o(a_vec), .epc1_o(a_epc1), .depc_o(a_depc),
    .dbg_epc_o(a_dbg_epc), .dbg_eps_o(a_eps), .exc_cause_o(a_cause),
    .exc_vaddr_o(a_vaddr), .dbg_cause_o(a_dbgc), .ps_o(a_ps));

  exc_entry_ctrl #(.HAS_DEPC(1'b0), .HW_ALIGN(1'b1)) i_exc_entry_ctrl_b (
    .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req_i), .gen_cause_i(gen_cause_i),
    .gen_has_addr_i(gen_has_addr_i), .ua_req_i(ua_req_i), .ibus_err_i(ibus_err_i),
    .dbus_err_i(dbus_err_i), .dbg_req_i(dbg_req_i), .dbg_cause_i(dbg_cause_i),
    .pc_i(pc_i), .addr_i(addr_i), .ps_i(ps_i), .cur_level_i(cur_level_i),
    .vec_valid_o(b_valid), .vec_sel_o(b_vec), .epc1_o(b_epc1), .depc_o(b_depc),
    .dbg_epc_o(b_dbg_epc), .dbg_eps_o(b_eps), .exc_cause_o(b_cause),
    .exc_vaddr_o(b_vaddr), .dbg_cause_o(b_dbgc), .ps_o(b_ps));

  int total = 0;
  int bad = 0;

  // bench models: a = default instance, b = no double PC, hardware alignment
  logic [31:0] ma_epc1 = 0, ma_depc = 0, ma_vaddr = 0, ma_dbg_epc = 0;
  logic [7:0]  ma_eps = 0, ma_ps = 0;
  logic [5:0]  ma_cause = 0, ma_dbgc = 0;
  logic [1:0]  ma_vec = 0;
  logic        ma_valid = 0;
  logic [31:0] mb_epc1 = 0, mb_vaddr = 0;
  logic [7:0]  mb_ps = 0;
  logic [5:0]  mb_cause = 0;
  logic [1:0]  mb_vec = 0;
  logic        mb_valid = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] gvec(input logic [7:0] ps);
    return ps[4] ? 2'd2 : (ps[5] ? 2'd1 : 2'd0);
  endfunction

  // general trap effect on the models, from R2..R5 and R8..R11
  task automatic model_general(input logic ua_traps_a);
    logic [5:0] ca, cb;
    logic aw_a, aw_b, tk_a, tk_b;
    tk_a = 1; aw_a = 1; tk_b = 1; aw_b = 1;
    if (ibus_err_i) begin ca = 6'd12; cb = 6'd12; end
    else if (dbus_err_i) begin ca = 6'd13; cb = 6'd13; end
    else begin
      if (ua_req_i && ua_traps_a) ca = 6'd9;
      else if (gen_req_i) begin ca = gen_cause_i; aw_a = gen_has_addr_i; end
      else begin ca = 0; tk_a = 0; end
      if (gen_req_i) begin cb = gen_cause_i; aw_b = gen_has_addr_i; end
      else begin cb = 0; tk_b = 0; end
    end
    ma_valid = tk_a;
    mb_valid = tk_b;
    if (tk_a) begin
      ma_vec = gvec(ps_i);
      if (ps_i[4]) ma_depc = pc_i; else ma_epc1 = pc_i;
      ma_cause = ca;
      if (aw_a) ma_vaddr = addr_i;
      ma_ps = ps_i | 8'h10;
    end
    if (tk_b) begin
      mb_vec = gvec(ps_i);
      mb_epc1 = pc_i;
      mb_cause = cb;
      if (aw_b) mb_vaddr = addr_i;
      mb_ps = ps_i | 8'h10;
    end
  endtask

  task automatic model_step();
    if (dbg_req_i && cur_level_i < 4'd6) begin
      ma_valid = 1; mb_valid = 1;
      ma_vec = 2'd3; mb_vec = 2'd3;
      ma_dbg_epc = pc_i; ma_eps = ps_i; ma_dbgc = dbg_cause_i;
      ma_ps = (ps_i & 8'hF0) | 8'h10 | 8'h06;
      mb_ps = ma_ps;
    end else begin
      model_general(1'b1);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R12 valid a"}, a_valid, ma_valid);
    chk({tag, " R12 valid b"}, b_valid, mb_valid);
    if (ma_valid) chk({tag, " R2/R3 vec a"}, a_vec, ma_vec);
    if (mb_valid) chk({tag, " R2/R3 vec b"}, b_vec, mb_vec);
    chk({tag, " R2 epc1 a"}, a_epc1, ma_epc1);
    chk({tag, " R3 depc a"}, a_depc, ma_depc);
    chk({tag, " R3 epc1 b"}, b_epc1, mb_epc1);
    chk({tag, " R4 cause a"}, a_cause, ma_cause);
    chk({tag, " R4 cause b"}, b_cause, mb_cause);
    chk({tag, " R5 vaddr a"}, a_vaddr, ma_vaddr);
    chk({tag, " R5 vaddr b"}, b_vaddr, mb_vaddr);
    chk({tag, " R4 ps a"}, a_ps, ma_ps);
    chk({tag, " R4 ps b"}, b_ps, mb_ps);
    chk({tag, " R7 dbg epc"}, a_dbg_epc, ma_dbg_epc);
    chk({tag, " R7 dbg eps"}, a_eps, ma_eps);
    chk({tag, " R7 dbg cause"}, a_dbgc, ma_dbgc);
  endtask

  // inputs are set at a falling edge; the rising edge latches; check at next falling edge
  task automatic fire(input string tag);
    model_step();
    @(negedge clk);
    gen_req_i = 0; ua_req_i = 0; ibus_err_i = 0; dbus_err_i = 0; dbg_req_i = 0;
    check_all(tag);
    @(negedge clk);
    ma_valid = 0; mb_valid = 0;
    check_all({tag, " idle"});
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    // R2 R3 R4 R5: every status word through a generic trap
    for (int p = 0; p < 256; p++) begin
      ps_i = 8'(p);
      gen_req_i = 1;
      gen_cause_i = 6'(p * 7 + 3);
      gen_has_addr_i = p[0];
      pc_i = 32'h4000_0000 + 32'(p * 4);
      addr_i = 32'hA000_0000 ^ 32'(p * 33);
      fire("R2/R3 sweep");
    end

    // R6 R7 R11: every interrupt level, half with a competing generic trap
    for (int l = 0; l < 16; l++) begin
      cur_level_i = 4'(l);
      ps_i = 8'(l * 13 + 1);
      dbg_req_i = 1;
      dbg_cause_i = 6'(l + 1);
      gen_req_i = l[0];
      gen_cause_i = 6'h2A;
      gen_has_addr_i = 0;
      pc_i = 32'h8000_0100 + 32'(l);
      fire("R6/R7/R11 debug");
    end
    cur_level_i = 0;

    // R8 R9 R10 R11: general source priority
    ps_i = 8'h00; pc_i = 32'h0000_1000; gen_cause_i = 6'h05;
    addr_i = 32'h1111_0001; ibus_err_i = 1; dbus_err_i = 1; ua_req_i = 1; gen_req_i = 1;
    fire("R9/R11 fetch first");
    addr_i = 32'h2222_0002; dbus_err_i = 1; ua_req_i = 1; gen_req_i = 1;
    fire("R10/R11 data next");
    addr_i = 32'h3333_0003; ua_req_i = 1; gen_req_i = 1; gen_has_addr_i = 0;
    fire("R8/R11 unaligned over generic");
    addr_i = 32'h4444_0004; ua_req_i = 1;
    fire("R8 unaligned alone");
    addr_i = 32'h5555_0005; ibus_err_i = 1; ps_i = 8'h30;
    fire("R9 fetch alone double");
    addr_i = 32'h6666_0006; dbus_err_i = 1; ps_i = 8'h20;
    fire("R10 data alone user");
    addr_i = 32'h7777_0007; gen_req_i = 1; gen_has_addr_i = 0; gen_cause_i = 6'h3F;
    fire("R5 generic without address");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  assign a_depc_unused = b_depc ^ b_dbg_epc ^ {24'd0, b_eps} ^ {26'd0, b_dbgc};
endmodule